// File: doc/BRIEF.md
# Dual-clock show-ahead FIFO

This block moves data words from one clock domain to an unrelated one. The producer offers a word by raising `put_i` and is held back by `full_o`. The consumer never asks for data. While `valid_o` is high, the oldest stored word is already on `dout_o`. Raising `got_i` for one read-clock cycle removes that word and shows the next one.

Each domain has its own clock and its own active-low asynchronous reset. The write and read positions pass between the domains as Gray-coded values through two-flop synchronizers. The write side computes `full_o` and the read side computes emptiness. Both flags lag the far side, so both err towards safety. The storage depth is the smallest power of two that is at least the larger of `MIN_DEPTH` and 3. The smallest depth the block ever builds is therefore 4.

Top module: `xdom_fifo`

## Requirements
- R1: While `wr_rst_ni` is low, `full_o` is 0. While `rd_rst_ni` is low, `valid_o` is 0. After both resets are released and before any write, both flags stay 0.
- R2: With no reads, the FIFO accepts exactly DEPTH words from back-to-back puts. DEPTH is the smallest power of two that is at least max(`MIN_DEPTH`, 3), which is 4 for the default `MIN_DEPTH` of 3. `full_o` is 1 once DEPTH words are held.
- R3: A put while `full_o` is 1 stores nothing. The rejected word never appears on `dout_o`, and the order of the accepted words is kept.
- R4: Words leave in the order they were accepted. Whenever `valid_o` is 1, `dout_o` holds the oldest unread word, with no request needed.
- R5: A cycle with `got_i` and `valid_o` both high removes the head word. Without `got_i`, `valid_o` stays high and `dout_o` stays unchanged.
- R6: `got_i` while `valid_o` is 0 is ignored. The FIFO does not underflow, and a word written later is presented intact.
- R7: Positions cross domains in Gray code, changing by at most one bit per cycle. A write becomes visible as `valid_o` within 8 read cycles. A drain clears `full_o` within 10 write cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk_i | input | 1 | Write-domain clock |
| wr_rst_ni | input | 1 | Write-domain asynchronous reset, active low |
| put_i | input | 1 | Store `din_i` if not full |
| din_i | input | DATA_W | Word to store |
| full_o | output | 1 | No free slot; puts are dropped |
| rd_clk_i | input | 1 | Read-domain clock |
| rd_rst_ni | input | 1 | Read-domain asynchronous reset, active low |
| got_i | input | 1 | Head word consumed |
| valid_o | output | 1 | A word is shown on `dout_o` |
| dout_o | output | DATA_W | Oldest unread word |

## Verification
The bench first fills the FIFO with reads off. Pushing past capacity shows the depth rounding and whether rejected words leak into the stream. A lone write after a long run of `got_i` on an empty FIFO shows whether a spurious consume moved the read position. Random write gaps are then run against a reader that takes every word, and separately against one that takes about a third of the cycles. The first stream stresses the empty boundary and the show-ahead latency. The second keeps the FIFO at full and separates correct back-pressure from lost or duplicated words.

// File: rtl/xdom_fifo_pkg.sv
package xdom_fifo_pkg;

  function automatic int fifo_depth(input int min_d);
    int lo;
    int d;
    lo = (min_d < 3) ? 3 : min_d;
    d  = 1;
    while (d < lo) d = d * 2;
    return d;
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b = g;
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/xdom_sync.sv
module xdom_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/xdom_wr_ctl.sv
module xdom_wr_ctl #(
  parameter int AW = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        put_i,
  input  logic [AW:0] rgray_i,
  output logic        we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0] wgray_o,
  output logic        full_o
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] wbin_q, wbin_d;

  assign full_o  = (wgray_o == {~rgray_i[PW-1:PW-2], rgray_i[PW-3:0]});
  assign we_o    = put_i & ~full_o;
  assign wbin_d  = wbin_q + PW'(we_o);
  assign waddr_o = wbin_q[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_o <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_o <= (wbin_d >> 1) ^ wbin_d;
    end
  end

  logic [PW-1:0] occ_w;
  assign occ_w = wbin_q - PW'(xdom_fifo_pkg::gray2bin(32'(rgray_i)));

  p_occupancy_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_w <= PW'(DEPTH));
  p_no_write_when_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (put_i && full_o) |=> $stable(wgray_o));
  p_gray_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(wgray_o ^ $past(wgray_o)) <= 1);
endmodule

// File: rtl/xdom_rd_ctl.sv
module xdom_rd_ctl #(
  parameter int AW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          got_i,
  input  logic [AW:0]   wgray_i,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rgray_o,
  output logic          valid_o
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] rbin_q, rbin_d;
  logic          re;

  assign valid_o = (rgray_o != wgray_i);
  assign re      = got_i & valid_o;
  assign rbin_d  = rbin_q + PW'(re);
  assign raddr_o = rbin_q[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_o <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_o <= (rbin_d >> 1) ^ rbin_d;
    end
  end

  logic [PW-1:0] avail_w;
  assign avail_w = PW'(xdom_fifo_pkg::gray2bin(32'(wgray_i))) - rbin_q;

  p_no_underflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avail_w <= PW'(DEPTH));
  p_head_kept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !got_i) |=> valid_o);
  p_idle_got_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o) |=> $stable(rgray_o));
  p_gray_step_rd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rgray_o ^ $past(rgray_o)) <= 1);
endmodule

// File: rtl/xdom_fifo.sv
module xdom_fifo #(
  parameter int DATA_W    = 16,
  parameter int MIN_DEPTH = 3
) (
  input  logic              wr_clk_i,
  input  logic              wr_rst_ni,
  input  logic              put_i,
  input  logic [DATA_W-1:0] din_i,
  output logic              full_o,
  input  logic              rd_clk_i,
  input  logic              rd_rst_ni,
  input  logic              got_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] dout_o
);
  localparam int DEPTH = xdom_fifo_pkg::fifo_depth(MIN_DEPTH);
  localparam int AW    = $clog2(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic              we;
  logic [AW-1:0]     waddr, raddr;
  logic [AW:0]       wgray, rgray, wgray_rs, rgray_ws;

  xdom_wr_ctl #(.AW(AW)) u_wr (
    .clk_i   (wr_clk_i),
    .rst_ni  (wr_rst_ni),
    .put_i   (put_i),
    .rgray_i (rgray_ws),
    .we_o    (we),
    .waddr_o (waddr),
    .wgray_o (wgray),
    .full_o  (full_o)
  );

  xdom_sync #(.W(AW+1)) u_sync_r2w (
    .clk_i  (wr_clk_i),
    .rst_ni (wr_rst_ni),
    .d_i    (rgray),
    .q_o    (rgray_ws)
  );

  xdom_sync #(.W(AW+1)) u_sync_w2r (
    .clk_i  (rd_clk_i),
    .rst_ni (rd_rst_ni),
    .d_i    (wgray),
    .q_o    (wgray_rs)
  );

  xdom_rd_ctl #(.AW(AW)) u_rd (
    .clk_i   (rd_clk_i),
    .rst_ni  (rd_rst_ni),
    .got_i   (got_i),
    .wgray_i (wgray_rs),
    .raddr_o (raddr),
    .rgray_o (rgray),
    .valid_o (valid_o)
  );

  // slot is stable until its pointer crosses back, so async read is safe
  always_ff @(posedge wr_clk_i) begin
    if (we) mem_q[waddr] <= din_i;
  end

  assign dout_o = mem_q[raddr];

  p_head_stable_r5: assert property (@(posedge rd_clk_i) disable iff (!rd_rst_ni)
    (valid_o && !got_i) |=> $stable(dout_o));
  p_reset_flags_r1: assert property (@(posedge rd_clk_i)
    (!rd_rst_ni) |-> !valid_o);
endmodule

// File: tb/sim_xdom_fifo.sv
`timescale 1ns/1ps
module sim_xdom_fifo;
  localparam int DW   = 16;
  localparam int MIND = 3;

  function automatic int exp_depth(input int m);
    int d;
    d = 1;
    while (d < ((m < 3) ? 3 : m)) d = d * 2;
    return d;
  endfunction
  localparam int EDEPTH = exp_depth(MIND);

  logic          wr_clk = 0, rd_clk = 0;
  logic          wr_rst_n = 0, rd_rst_n = 0;
  logic          put = 0, got = 0;
  logic [DW-1:0] din = '0;
  logic          full, valid;
  logic [DW-1:0] dout;

  always #3.5 wr_clk = ~wr_clk;
  always #2.5 rd_clk = ~rd_clk;

  xdom_fifo #(.DATA_W(DW), .MIN_DEPTH(MIND)) u0 (
    .wr_clk_i (wr_clk), .wr_rst_ni (wr_rst_n), .put_i (put), .din_i (din),
    .full_o (full),
    .rd_clk_i (rd_clk), .rd_rst_ni (rd_rst_n), .got_i (got),
    .valid_o (valid), .dout_o (dout)
  );

  int n_chk = 0, n_err = 0;
  logic [DW-1:0] sb_q[$];
  int  got_rate = 0;
  bit  rd_go = 0;
  logic [DW-1:0] seq = 16'h1000;
  bit  finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  endtask

  // driver: one put per call; pushes expectation only when accepted
  task automatic wr_word(input logic [DW-1:0] d, output bit acc);
    put = 1;
    din = d;
    acc = !full;
    if (acc) sb_q.push_back(d);
    @(negedge wr_clk);
    put = 0;
  endtask

  task automatic wr_stream(input int n, input int gap_max);
    bit acc;
    for (int i = 0; i < n; i++) begin
      do wr_word(seq, acc); while (!acc);
      seq++;
      repeat ($urandom_range(gap_max)) @(negedge wr_clk);
    end
  endtask

  task automatic drain();
    got_rate = 100;
    wait (sb_q.size() == 0);
    repeat (10) @(negedge rd_clk);
  endtask

  // monitor: compare the head at each consume
  always @(negedge rd_clk) begin
    if (rd_go) begin
      bit g;
      g = ($urandom_range(99) < got_rate);
      if (valid) begin
        if (sb_q.size() == 0)
          chk(0, "R4 valid with nothing written", 32'(valid), 0);
        else if (g) begin
          chk(dout == sb_q[0], "R4/R5 head word order", 32'(dout), 32'(sb_q[0]));
          void'(sb_q.pop_front());
        end
      end
      got = g;
    end
  end

  initial begin
    #500000;
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    bit acc;
    int n_acc;
    logic [DW-1:0] first;

    // R1 reset state, resets released at different times
    repeat (3) @(negedge rd_clk);
    chk(full == 0, "R1 full in reset", 32'(full), 0);
    chk(valid == 0, "R1 valid in reset", 32'(valid), 0);
    @(negedge wr_clk); wr_rst_n = 1;
    repeat (4) @(negedge rd_clk); rd_rst_n = 1;
    repeat (5) @(negedge rd_clk);
    chk(full == 0, "R1 full after reset", 32'(full), 0);
    chk(valid == 0, "R1 valid after reset", 32'(valid), 0);
    rd_go = 1;

    // R2/R3 fill past capacity with reads off
    got_rate = 0;
    @(negedge wr_clk);
    n_acc = 0;
    first = seq;
    for (int i = 0; i < EDEPTH + 3; i++) begin
      wr_word(seq, acc);
      if (acc) n_acc++;
      seq++;
    end
    chk(n_acc == EDEPTH, "R2 words accepted before full", 32'(n_acc), 32'(EDEPTH));
    chk(full == 1, "R2 full at capacity", 32'(full), 1);
    repeat (10) @(negedge rd_clk);
    chk(valid == 1, "R4 valid without request", 32'(valid), 1);
    chk(dout == first, "R4 oldest word shown", 32'(dout), 32'(first));
    repeat (5) @(negedge rd_clk);
    chk(dout == first, "R5 head held without got", 32'(dout), 32'(first));
    drain();
    chk(valid == 0, "R3 rejected words absent", 32'(valid), 0);
    repeat (10) @(negedge wr_clk);
    chk(full == 0, "R7 full clears after drain", 32'(full), 0);

    // R6 got on an empty FIFO
    got_rate = 100;
    repeat (20) @(negedge rd_clk);
    got_rate = 0;
    @(negedge rd_clk);
    chk(valid == 0, "R6 no underflow", 32'(valid), 0);
    @(negedge wr_clk);
    first = seq;
    wr_word(seq, acc);
    seq++;
    repeat (8) @(negedge rd_clk);
    chk(valid == 1, "R7 write visible within 8 read cycles", 32'(valid), 1);
    chk(dout == first, "R6 word intact after idle got", 32'(dout), 32'(first));
    drain();

    // fast reader, random write gaps
    got_rate = 100;
    @(negedge wr_clk);
    wr_stream(300, 3);
    drain();
    chk(sb_q.size() == 0, "R4 fast reader all words out", 32'(sb_q.size()), 0);

    // slow reader: FIFO sits at full, back-pressure path
    got_rate = 30;
    @(negedge wr_clk);
    wr_stream(300, 1);
    drain();
    chk(sb_q.size() == 0, "R3 slow reader all words out", 32'(sb_q.size()), 0);
    chk(valid == 0, "R4 empty at end", 32'(valid), 0);

    finish_run();
  end
endmodule